// File: doc/BRIEF.md
# Four-Mode Power and Clock-Enable Controller

This block decides, cycle by cycle, which clocks in a small system are running and whether the core power rail is on. It has four operating modes. In the full-speed mode the processor runs from the PLL and each peripheral clock follows its bit in an enable register. In the bypass mode the PLL is powered down and the system runs straight from the reference oscillator. In the CPU-stopped mode only the processor clock is halted, and any peripheral interrupt resumes full speed. In the power-off mode the core rail is dropped through a power-enable pin, and only the enabled external interrupt lines or the real-time alarm can bring it back.

Software requests a mode by pulsing a request strobe with a two-bit code. The block returns to full speed from bypass only after the PLL reports lock. After a wake from power-off it waits a fixed number of power-settling cycles before it enables any clock. It also produces the bus-clock enable ticks: the processor clock runs four times as fast as the system bus clock and eight times as fast as the peripheral bus clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the reported mode is full speed (code 0), `cpu_clk_en`=1, every `periph_clk_en` bit=1, `pwren`=1, `pll_pd`=0, `clk_sel_pll`=1 and `sleep_err`=0.
- R2: A write to the peripheral enable register sets `periph_clk_en` to the written value from the next cycle, in every mode except power-off and power-settling.
- R3: Mode codes are 0 full speed, 1 bypass, 2 CPU-stopped, 3 power-off. From full speed, a request for another mode takes effect in the next cycle. In bypass only a request for code 0 is accepted. In CPU-stopped, power-off and the two transition phases every request is ignored.
- R4: In bypass `pll_pd`=1, `clk_sel_pll`=0 and `cpu_clk_en`=1.
- R5: A request to leave bypass sets `pll_pd`=0 in the next cycle. The block keeps `clk_sel_pll`=0 and reports code 1 until `pll_lock` is sampled high. In the cycle after that it reports code 0 with `clk_sel_pll`=1.
- R6: In CPU-stopped `cpu_clk_en`=0 and the peripheral clocks follow the enable register. Any `periph_irq` bit returns the block to full speed in the next cycle, even when a mode request arrives in the same cycle.
- R7: In power-off `pwren`=0, `cpu_clk_en`=0, every `periph_clk_en` bit=0, `pll_pd`=1, and both bus ticks are 0.
- R8: Only a wake source whose wake-mask bit is set wakes the block from power-off. Mask bit i stands for `ext_irq[i]` and bit NEXT for `rtc_alarm`. Masked sources and `periph_irq` leave the block in power-off.
- R9: On a wake, `pwren` rises in the next cycle. The clocks stay off and code 3 is reported for exactly PWR_STABLE_CYC cycles, with the PLL powered up. Then the block enters full speed.
- R10: A power-off request while the wake mask is zero is refused: the mode stays at full speed and `sleep_err` becomes 1. `sleep_err` is updated on every request pulse and is 1 only after a refused request.
- R11: Outside power-off and power-settling, `hclk_tick` is high in one cycle of every HDIV and `pclk_tick` in one cycle of every PDIV. `pclk_tick` is high only in a cycle where `hclk_tick` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req_valid | input | 1 | One-cycle mode request strobe |
| mode_req | input | 2 | Requested mode code |
| clk_en_wr | input | 1 | Write strobe for the peripheral enable register |
| clk_en_data | input | NPERIPH | New peripheral enable value |
| wake_mask_wr | input | 1 | Write strobe for the wake mask |
| wake_mask_data | input | NEXT+1 | New wake mask (bit NEXT is the alarm) |
| ext_irq | input | NEXT | External interrupt lines |
| rtc_alarm | input | 1 | Real-time alarm |
| periph_irq | input | NPERIPH | Peripheral interrupts |
| pll_lock | input | 1 | PLL lock indication |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | NPERIPH | Peripheral clock enables |
| hclk_tick | output | 1 | System bus clock enable tick |
| pclk_tick | output | 1 | Peripheral bus clock enable tick |
| pll_pd | output | 1 | PLL power-down |
| clk_sel_pll | output | 1 | 1 selects the PLL, 0 the reference |
| pwren | output | 1 | Core power enable pin |
| cur_mode | output | 2 | Reported mode code |
| sleep_err | output | 1 | A power-off request was refused |

## Verification
Two things can land in the same cycle while the processor clock is stopped: a peripheral interrupt and a mode request. The bench drives both on one edge and expects the interrupt to win, with full speed reported in the next cycle and the request dropped. In power-off, every masked wake source and every peripheral interrupt are driven together in one cycle, and the bench expects the rail to stay down. The single enabled source is then fired, and the settling window is counted cycle by cycle against PWR_STABLE_CYC.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SLOW   = 2'd1,
    MODE_IDLE   = 2'd2,
    MODE_SLEEP  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_BYPASS   = 3'd1,
    ST_CPU_OFF  = 3'd2,
    ST_OFF      = 3'd3,
    ST_RELOCK   = 3'd4,
    ST_POWER_UP = 3'd5
  } state_e;

  // Mode code reported to software for each internal state.
  function automatic logic [1:0] report_mode(state_e s);
    case (s)
      ST_RUN:      return MODE_NORMAL;
      ST_BYPASS,
      ST_RELOCK:   return MODE_SLOW;
      ST_CPU_OFF:  return MODE_IDLE;
      default:     return MODE_SLEEP;
    endcase
  endfunction

  // True when the core rail is up and clocks may run.
  function automatic logic clocks_alive(state_e s);
    return !(s == ST_OFF || s == ST_POWER_UP);
  endfunction

  // True in the cycle where a free-running count hits a multiple of div.
  function automatic logic ratio_edge(int unsigned cnt, int unsigned div);
    return (cnt % div) == 0;
  endfunction

endpackage

// File: rtl/pwr_ratio_div.sv
`timescale 1ns/1ps
module pwr_ratio_div
  import pwr_mode_pkg::*;
#(
  parameter int unsigned HDIV = 4,
  parameter int unsigned PDIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alive,
  output logic hclk_tick,
  output logic pclk_tick
);
  localparam int unsigned CW = (PDIV > 1) ? $clog2(PDIV) : 1;

  logic [CW-1:0] phase;
  logic          h_edge;
  logic          p_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          phase <= '0;
    else if (phase == CW'(PDIV - 1))     phase <= '0;
    else                                 phase <= phase + 1'b1;
  end

  assign h_edge    = ratio_edge(int'(phase), HDIV);
  assign p_edge    = ratio_edge(int'(phase), PDIV);
  assign hclk_tick = alive & h_edge;
  assign pclk_tick = alive & p_edge;

  assert_pclk_in_hclk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_tick |-> hclk_tick);

  assert_ticks_dead_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !alive |-> (!hclk_tick && !pclk_tick));

endmodule

// File: rtl/pwr_wake_gate.sv
`timescale 1ns/1ps
module pwr_wake_gate #(
  parameter int unsigned NEXT           = 4,
  parameter int unsigned PWR_STABLE_CYC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_irq,
  input  logic            rtc_alarm,
  input  logic [NEXT:0]   wake_mask,
  input  logic            in_sleep,
  input  logic            in_powerup,
  output logic            wake_hit,
  output logic            stable_done
);
  localparam int unsigned SW = $clog2(PWR_STABLE_CYC + 1);

  logic [SW-1:0] settle_cnt;
  logic [NEXT:0] sources;

  assign sources     = {rtc_alarm, ext_irq};
  assign wake_hit    = |(sources & wake_mask);
  assign stable_done = (settle_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           settle_cnt <= '0;
    else if (in_sleep && wake_hit)        settle_cnt <= SW'(PWR_STABLE_CYC - 1);
    else if (in_powerup && !stable_done)  settle_cnt <= settle_cnt - 1'b1;
  end

  assert_settle_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && wake_hit && (PWR_STABLE_CYC > 1)) |=> !stable_done);

  assert_settle_counts_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_powerup && !stable_done) |=> (settle_cnt == $past(settle_cnt) - 1'b1));

endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req,
  input  logic       mask_any,
  input  logic       wake_hit,
  input  logic       irq_any,
  input  logic       pll_lock,
  input  logic       stable_done,
  output state_e     st,
  output logic       sleep_err
);
  state_e nxt;
  logic   refuse;

  always_comb begin
    nxt    = st;
    refuse = 1'b0;
    case (st)
      ST_RUN: begin
        if (req_valid) begin
          case (req)
            MODE_SLOW:  nxt = ST_BYPASS;
            MODE_IDLE:  nxt = ST_CPU_OFF;
            MODE_SLEEP: begin
              if (mask_any) nxt = ST_OFF;
              else          refuse = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_BYPASS:   if (req_valid && req == MODE_NORMAL) nxt = ST_RELOCK;
      ST_RELOCK:   if (pll_lock)    nxt = ST_RUN;
      ST_CPU_OFF:  if (irq_any)     nxt = ST_RUN;
      ST_OFF:      if (wake_hit)    nxt = ST_POWER_UP;
      ST_POWER_UP: if (stable_done) nxt = ST_RUN;
      default:     nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_RUN;
      sleep_err <= 1'b0;
    end else begin
      st <= nxt;
      if (req_valid) sleep_err <= refuse;
    end
  end

  assert_refused_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && req_valid && req == MODE_SLEEP && !mask_any)
      |=> (sleep_err && st == ST_RUN));

  assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && !wake_hit) |=> st == ST_OFF);

  assert_idle_irq_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CPU_OFF && irq_any) |=> st == ST_RUN);

  assert_relock_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RELOCK && !pll_lock) |=> st == ST_RELOCK);

  assert_idle_ignores_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CPU_OFF && !irq_any) |=> st == ST_CPU_OFF);

endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NPERIPH        = 8,
  parameter int unsigned NEXT           = 4,
  parameter int unsigned PWR_STABLE_CYC = 16,
  parameter int unsigned HDIV           = 4,
  parameter int unsigned PDIV           = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_req_valid,
  input  logic [1:0]         mode_req,
  input  logic               clk_en_wr,
  input  logic [NPERIPH-1:0] clk_en_data,
  input  logic               wake_mask_wr,
  input  logic [NEXT:0]      wake_mask_data,
  input  logic [NEXT-1:0]    ext_irq,
  input  logic               rtc_alarm,
  input  logic [NPERIPH-1:0] periph_irq,
  input  logic               pll_lock,
  output logic               cpu_clk_en,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               hclk_tick,
  output logic               pclk_tick,
  output logic               pll_pd,
  output logic               clk_sel_pll,
  output logic               pwren,
  output logic [1:0]         cur_mode,
  output logic               sleep_err
);
  logic [NPERIPH-1:0] en_reg;
  logic [NEXT:0]      wake_mask;
  state_e             st;
  logic               wake_hit;
  logic               stable_done;
  logic               alive;
  logic               in_sleep;
  logic               in_powerup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_reg    <= '1;
      wake_mask <= '0;
    end else begin
      if (clk_en_wr)    en_reg    <= clk_en_data;
      if (wake_mask_wr) wake_mask <= wake_mask_data;
    end
  end

  assign alive      = clocks_alive(st);
  assign in_sleep   = (st == ST_OFF);
  assign in_powerup = (st == ST_POWER_UP);
  assign cur_mode   = report_mode(st);

  pwr_mode_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (mode_req_valid),
    .req         (mode_req),
    .mask_any    (|wake_mask),
    .wake_hit    (wake_hit),
    .irq_any     (|periph_irq),
    .pll_lock    (pll_lock),
    .stable_done (stable_done),
    .st          (st),
    .sleep_err   (sleep_err)
  );

  pwr_wake_gate #(.NEXT(NEXT), .PWR_STABLE_CYC(PWR_STABLE_CYC)) i_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_irq     (ext_irq),
    .rtc_alarm   (rtc_alarm),
    .wake_mask   (wake_mask),
    .in_sleep    (in_sleep),
    .in_powerup  (in_powerup),
    .wake_hit    (wake_hit),
    .stable_done (stable_done)
  );

  pwr_ratio_div #(.HDIV(HDIV), .PDIV(PDIV)) i_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .alive     (alive),
    .hclk_tick (hclk_tick),
    .pclk_tick (pclk_tick)
  );

  always_comb begin
    cpu_clk_en    = 1'b1;
    periph_clk_en = en_reg;
    pll_pd        = 1'b0;
    clk_sel_pll   = 1'b1;
    pwren         = 1'b1;
    case (st)
      ST_BYPASS: begin
        pll_pd      = 1'b1;
        clk_sel_pll = 1'b0;
      end
      ST_RELOCK:  clk_sel_pll = 1'b0;
      ST_CPU_OFF: cpu_clk_en  = 1'b0;
      ST_OFF: begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = '0;
        pll_pd        = 1'b1;
        clk_sel_pll   = 1'b0;
        pwren         = 1'b0;
      end
      ST_POWER_UP: begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = '0;
        clk_sel_pll   = 1'b0;
      end
      default: ;
    endcase
  end

  assert_sleep_rail_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |-> (!pwren && periph_clk_en == '0 && !cpu_clk_en));

  assert_bypass_pll_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_SLOW && !clk_sel_pll && st == ST_BYPASS) |-> pll_pd);

  assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_wr && st == ST_RUN && !mode_req_valid) |=> periph_clk_en == $past(clk_en_data));

  assert_relock_on_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RELOCK && !pll_lock) |=> (!clk_sel_pll && !pll_pd));

  assert_wake_rail_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && wake_hit) |=> (pwren && !cpu_clk_en));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int NP  = 8;
  localparam int NX  = 4;
  localparam int STB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_req_valid = 1'b0;
  logic [1:0]    mode_req = 2'd0;
  logic          clk_en_wr = 1'b0;
  logic [NP-1:0] clk_en_data = '0;
  logic          wake_mask_wr = 1'b0;
  logic [NX:0]   wake_mask_data = '0;
  logic [NX-1:0] ext_irq = '0;
  logic          rtc_alarm = 1'b0;
  logic [NP-1:0] periph_irq = '0;
  logic          pll_lock = 1'b0;
  logic          cpu_clk_en, hclk_tick, pclk_tick, pll_pd, clk_sel_pll, pwren, sleep_err;
  logic [NP-1:0] periph_clk_en;
  logic [1:0]    cur_mode;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;
  logic [NP-1:0] cur_en = '1;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.NPERIPH(NP), .NEXT(NX), .PWR_STABLE_CYC(STB), .HDIV(4), .PDIV(8)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_req_valid(mode_req_valid), .mode_req(mode_req),
    .clk_en_wr(clk_en_wr), .clk_en_data(clk_en_data), .wake_mask_wr(wake_mask_wr),
    .wake_mask_data(wake_mask_data), .ext_irq(ext_irq), .rtc_alarm(rtc_alarm),
    .periph_irq(periph_irq), .pll_lock(pll_lock), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .hclk_tick(hclk_tick), .pclk_tick(pclk_tick),
    .pll_pd(pll_pd), .clk_sel_pll(clk_sel_pll), .pwren(pwren), .cur_mode(cur_mode),
    .sleep_err(sleep_err)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic request(logic [1:0] m);
    mode_req_valid = 1'b1;
    mode_req = m;
    @(negedge clk);
    mode_req_valid = 1'b0;
  endtask

  task automatic write_en(logic [NP-1:0] v);
    clk_en_wr = 1'b1;
    clk_en_data = v;
    cur_en = v;
    @(negedge clk);
    clk_en_wr = 1'b0;
  endtask

  task automatic write_mask(logic [NX:0] v);
    wake_mask_wr = 1'b1;
    wake_mask_data = v;
    @(negedge clk);
    wake_mask_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "mode", cur_mode, 0);
    chk("R1", "cpu", cpu_clk_en, 1);
    chk("R1", "periph", periph_clk_en, 8'hFF);
    chk("R1", "pwren", pwren, 1);
    chk("R1", "pll_pd", pll_pd, 0);
    chk("R1", "sel", clk_sel_pll, 1);
    chk("R1", "err", sleep_err, 0);

    // R11 tick ratio over 64 cycles
    begin
      int h = 0, p = 0, orphan = 0;
      for (int c = 0; c < 64; c++) begin
        if (hclk_tick) h++;
        if (pclk_tick) p++;
        if (pclk_tick && !hclk_tick) orphan++;
        @(negedge clk);
      end
      chk("R11", "hclk count", h, 64 / 4);
      chk("R11", "pclk count", p, 64 / 8);
      chk("R11", "pclk without hclk", orphan, 0);
    end

    // R2 enable register patterns
    begin
      logic [NP-1:0] pats [6] = '{8'h00, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'hFF};
      foreach (pats[k]) begin
        write_en(pats[k]);
        chk("R2", "periph", periph_clk_en, pats[k]);
      end
    end

    // R3/R4 bypass entry and ignored requests
    write_en(8'hC3);
    request(2'd1);
    chk("R3", "mode slow", cur_mode, 1);
    chk("R4", "pll_pd", pll_pd, 1);
    chk("R4", "sel", clk_sel_pll, 0);
    chk("R4", "cpu", cpu_clk_en, 1);
    chk("R2", "periph slow", periph_clk_en, 8'hC3);
    request(2'd2);
    chk("R3", "idle ignored in slow", cur_mode, 1);
    request(2'd3);
    chk("R3", "sleep ignored in slow", cur_mode, 1);
    chk("R3", "rail after ignored", pwren, 1);

    // R5 relock
    pll_lock = 1'b0;
    request(2'd0);
    chk("R5", "mode relock", cur_mode, 1);
    chk("R5", "pll_pd relock", pll_pd, 0);
    chk("R5", "sel relock", clk_sel_pll, 0);
    repeat (3) @(negedge clk);
    chk("R5", "still waiting", cur_mode, 1);
    chk("R5", "still on ref", clk_sel_pll, 0);
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R5", "mode after lock", cur_mode, 0);
    chk("R5", "sel after lock", clk_sel_pll, 1);

    // R6 CPU-stopped, per-bit interrupt sweep
    write_en(8'h3C);
    for (int b = 0; b < NP; b++) begin
      request(2'd2);
      chk("R6", "mode idle", cur_mode, 2);
      chk("R6", "cpu off", cpu_clk_en, 0);
      chk("R6", "periph idle", periph_clk_en, 8'h3C);
      request(2'd1);
      chk("R3", "slow ignored in idle", cur_mode, 2);
      periph_irq = NP'(1) << b;
      if (b == 0) begin
        mode_req_valid = 1'b1;
        mode_req = 2'd1;
      end
      @(negedge clk);
      periph_irq = '0;
      mode_req_valid = 1'b0;
      chk("R6", "irq wakes", cur_mode, 0);
      chk("R6", "cpu back", cpu_clk_en, 1);
    end

    // R10 refused power-off
    write_mask('0);
    request(2'd3);
    chk("R10", "mode stays", cur_mode, 0);
    chk("R10", "err set", sleep_err, 1);
    chk("R10", "rail on", pwren, 1);
    request(2'd0);
    chk("R10", "err cleared", sleep_err, 0);

    // R7/R8/R9 wake-source sweep
    for (int i = 0; i <= NX; i++) begin
      logic [NX:0] sel_m;
      logic [NX:0] others;
      int n;
      int ticks;
      sel_m = (NX+1)'(1) << i;
      others = ~sel_m;
      write_mask(sel_m);
      request(2'd3);
      chk("R7", "mode off", cur_mode, 3);
      chk("R7", "pwren", pwren, 0);
      chk("R7", "cpu", cpu_clk_en, 0);
      chk("R7", "periph", periph_clk_en, 0);
      chk("R7", "pll_pd", pll_pd, 1);
      chk("R10", "err after accepted", sleep_err, 0);
      ticks = 0;
      for (int c = 0; c < 16; c++) begin
        if (hclk_tick || pclk_tick) ticks++;
        @(negedge clk);
      end
      chk("R7", "ticks in off", ticks, 0);
      ext_irq = others[NX-1:0];
      rtc_alarm = others[NX];
      periph_irq = '1;
      @(negedge clk);
      ext_irq = '0;
      rtc_alarm = 1'b0;
      periph_irq = '0;
      chk("R8", "masked stays off", pwren, 0);
      chk("R8", "masked mode", cur_mode, 3);
      ext_irq = sel_m[NX-1:0];
      rtc_alarm = sel_m[NX];
      @(negedge clk);
      ext_irq = '0;
      rtc_alarm = 1'b0;
      chk("R9", "rail up", pwren, 1);
      chk("R9", "cpu still off", cpu_clk_en, 0);
      chk("R9", "pll powered", pll_pd, 0);
      n = 0;
      while (cur_mode == 2'd3 && pwren && n < 100) begin
        if (periph_clk_en != '0 || cpu_clk_en) n += 1000;
        n++;
        @(negedge clk);
      end
      chk("R9", "settle cycles", n, STB);
      chk("R9", "mode normal", cur_mode, 0);
      chk("R9", "cpu on", cpu_clk_en, 1);
      chk("R2", "enables kept", periph_clk_en, cur_en);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule